// File: doc/BRIEF.md
# Direct-mapped data cache with per-access bypass

This block sits between a processor load/store port and a main-memory port as wide as one cache line. Cacheable reads look up a direct-mapped array of 64 lines of 32 bytes. A hit answers the next cycle. A miss fetches the whole line in one memory beat and allocates it. Writes go through to memory. A write that hits updates the cached word, and a write that misses does not allocate.

Any access can be made non-cacheable in two ways. The first is address bit 29, which selects an uncached alias of the same physical location. The second is the request's `req_nocache` flag, which applies to whatever the address is. A non-cacheable access skips the tag lookup, goes straight to memory, never allocates and never displaces a line. A snoop write port carries writes that another unit makes directly to memory. Such a write updates a cached copy that is present and leaves the cache alone otherwise. An optional next-line prefetch can be switched on with `pf_enable`. After a demand miss it fetches the following line. A read hit on the most recently prefetched line fetches the line after that, so a sequential stream keeps running ahead.

The processor side uses a valid/ready handshake. A request is taken in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only when the cache is idle, and the requester must hold the request stable until it is taken. The memory request side is also valid/ready. The cache holds the address, data and direction unchanged while `mem_req_ready` is low. The cache keeps at most one memory read outstanding. Memory returns read data with a single-cycle `mem_rsp_valid` strobe, and that strobe cannot be back-pressured.

Top module: `dcache_bypass`

## Requirements
- R1: A synchronous active-high reset clears every valid bit. After reset `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0. The first cacheable read after reset misses.
- R2: A cacheable read miss issues one memory read whose address is the line base, with bits [4:0] zero. The read returns a 256-bit line in which word k occupies bits [32k+31:32k]. `rsp_valid` rises the cycle after `mem_rsp_valid` and carries word `addr[4:2]`.
- R3: A cacheable read hit raises `rsp_valid` in the cycle right after the request is taken and issues no memory request.
- R4: An address with bit 29 set is serviced uncached, and the memory address always has bit 29 cleared. Bit 29 takes no part in the tag, so an alias access reaches the same location as its cached twin.
- R5: `req_nocache` high forces an uncached access whatever the address.
- R6: An uncached read or write does no tag match and no allocation. A line already cached at the same index, or at the same address, keeps its tag and its data. An address first read uncached still misses on its next cacheable read.
- R7: Every processor write goes to memory as one word write at the word address, with bit 29 cleared. A cacheable write hit also updates the cached word. A write miss allocates nothing. `rsp_valid` for a write rises the cycle after memory accepts it.
- R8: A `snp_valid` write whose address matches a valid line replaces that word in the line. A snoop write to an absent line allocates nothing.
- R9: With `pf_enable` high, the fill of a demand miss on line N is followed, once no request is waiting, by a memory read of line N+1 (base + 32). That read fills the cache.
- R10: With `pf_enable` high, a read hit on the most recently prefetched line triggers a prefetch of the line after it.
- R11: A prefetch is dropped when its target line is already valid or when a demand request is taken first. No prefetch is issued while `pf_enable` is low, or after reset before a demand miss.
- R12: While the memory port is stalled, `mem_req_valid`, `mem_req_addr` and `mem_req_write` stay unchanged. Only one memory read is outstanding at a time. `req_ready` is low from the cycle after a request is taken until its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pf_enable | input | 1 | Enables next-line prefetch |
| req_valid | input | 1 | Processor request valid |
| req_ready | output | 1 | Cache can take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_nocache | input | 1 | Forces an uncached access |
| req_addr | input | 32 | Byte address, word aligned |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 32 | Load data (0 for stores) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = word write, 0 = line read |
| mem_req_addr | output | 32 | Line base for reads, word address for writes |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Line read data strobe |
| mem_rsp_data | input | 256 | Line read data |
| snp_valid | input | 1 | External memory write seen |
| snp_addr | input | 32 | Snooped word address |
| snp_data | input | 32 | Snooped word data |

## Verification
A hit answers in the cycle right after the request is taken. A miss or uncached read answers the cycle after the memory data strobe. A write answers the cycle after memory accepts it. A prefetch read leaves the cache a cycle after the demand fill, once the processor side is quiet. The bench drives every input on falling edges and samples on falling edges. Its access task counts the falling edges between the taking of a request and `rsp_valid`, and records whether `mem_rsp_valid` was high on the edge before. Each result is therefore checked in the cycle it is due, not just at some later point. A bench memory model counts line reads and word writes, so hits, bypasses and prefetches are told apart by the exact number of memory reads each access adds. The model stalls its ready line one cycle in three, so every handshake is exercised under back-pressure.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  typedef enum logic [1:0] {K_FILL, K_BYP, K_WR, K_PF} kind_e;
  typedef enum logic [1:0] {S_IDLE, S_MREQ, S_MRSP} state_e;
endpackage

// File: rtl/dcb_store.sv
module dcb_store #(
  parameter int AW         = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int IDX_W      = 6,
  parameter int BYP_BIT    = 29
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [AW-1:0]                    lk_addr,
  output logic                             lk_hit,
  output logic [WORD_W-1:0]                lk_word,
  input  logic [AW-1:0]                    pf_addr,
  output logic                             pf_hit,
  input  logic                             fill_en,
  input  logic [AW-1:0]                    fill_addr,
  input  logic [LINE_WORDS*WORD_W-1:0]     fill_data,
  input  logic                             wr_en,
  input  logic [AW-1:0]                    wr_addr,
  input  logic [WORD_W-1:0]                wr_data,
  input  logic                             snp_en,
  input  logic [AW-1:0]                    snp_addr,
  input  logic [WORD_W-1:0]                snp_data
);
  localparam int LINES    = 1 << IDX_W;
  localparam int LINE_B   = LINE_WORDS * WORD_W / 8;
  localparam int OFF_W    = $clog2(LINE_B);
  localparam int WB_W     = $clog2(WORD_W / 8);
  localparam int WSEL_W   = OFF_W - WB_W;
  localparam int TAG_W    = AW - OFF_W - IDX_W;
  localparam int LINE_W   = LINE_WORDS * WORD_W;
  localparam logic [AW-1:0] BYP_MASK = AW'(1) << BYP_BIT;

  logic [LINE_W-1:0] data_q [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINES-1:0]  vld_q;

  function automatic logic [IDX_W-1:0] f_idx(input logic [AW-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] f_tag(input logic [AW-1:0] a);
    logic [AW-1:0] c;
    c = a & ~BYP_MASK;
    return c[AW-1:OFF_W+IDX_W];
  endfunction

  function automatic logic [WSEL_W-1:0] f_ws(input logic [AW-1:0] a);
    return a[WB_W +: WSEL_W];
  endfunction

  function automatic logic f_match(input logic [AW-1:0] a, input logic [IDX_W-1:0] i,
                                   input logic [TAG_W-1:0] t, input logic v);
    return v && (t == f_tag(a)) && (i == f_idx(a));
  endfunction

  logic [WORD_W-1:0] lk_words [LINE_WORDS];
  logic [IDX_W-1:0]  lk_i, pf_i, sn_i, fi_i, wr_i;
  logic              snp_hit, snp_in_fill;

  assign lk_i = f_idx(lk_addr);
  assign pf_i = f_idx(pf_addr);
  assign sn_i = f_idx(snp_addr);
  assign fi_i = f_idx(fill_addr);
  assign wr_i = f_idx(wr_addr);

  assign lk_hit = f_match(lk_addr, lk_i, tag_q[lk_i], vld_q[lk_i]);
  assign pf_hit = f_match(pf_addr, pf_i, tag_q[pf_i], vld_q[pf_i]);

  // a snoop landing on the line being filled this cycle patches the fill
  assign snp_in_fill = fill_en && (fi_i == sn_i) && (f_tag(fill_addr) == f_tag(snp_addr));
  assign snp_hit = snp_en && (f_match(snp_addr, sn_i, tag_q[sn_i], vld_q[sn_i]) || snp_in_fill);

  for (genvar k = 0; k < LINE_WORDS; k++) begin : g_split
    assign lk_words[k] = data_q[lk_i][k*WORD_W +: WORD_W];
  end
  assign lk_word = lk_words[f_ws(lk_addr)];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (fill_en) begin
      vld_q[fi_i] <= 1'b1;
      tag_q[fi_i] <= f_tag(fill_addr);
    end
  end

  // fill first, then processor write, then snoop: later writes win
  always_ff @(posedge clk) begin
    if (fill_en) data_q[fi_i] <= fill_data;
    for (int k = 0; k < LINE_WORDS; k++) begin
      if (wr_en && f_ws(wr_addr) == WSEL_W'(k))
        data_q[wr_i][k*WORD_W +: WORD_W] <= wr_data;
      if (snp_hit && f_ws(snp_addr) == WSEL_W'(k))
        data_q[sn_i][k*WORD_W +: WORD_W] <= snp_data;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{lk_addr[WB_W-1:0], pf_addr[OFF_W-1:0], fill_addr[OFF_W-1:0],
                         wr_addr[WB_W-1:0], snp_addr[WB_W-1:0]};
endmodule

// File: rtl/dcb_ctrl.sv
module dcb_ctrl
  import dcb_pkg::*;
#(
  parameter int AW         = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int BYP_BIT    = 29
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         pf_enable,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic                         req_nocache,
  input  logic [AW-1:0]                req_addr,
  input  logic [WORD_W-1:0]            req_wdata,
  output logic                         rsp_valid,
  output logic [WORD_W-1:0]            rsp_rdata,
  input  logic                         lk_hit,
  input  logic [WORD_W-1:0]            lk_word,
  output logic [AW-1:0]                pf_addr,
  input  logic                         pf_hit,
  output logic                         wr_en,
  output logic                         fill_en,
  output logic [AW-1:0]                fill_addr,
  output logic                         mem_req_valid,
  input  logic                         mem_req_ready,
  output logic                         mem_req_write,
  output logic [AW-1:0]                mem_req_addr,
  output logic [WORD_W-1:0]            mem_req_wdata,
  input  logic                         mem_rsp_valid,
  input  logic [LINE_WORDS*WORD_W-1:0] mem_rsp_data
);
  localparam int LINE_B = LINE_WORDS * WORD_W / 8;
  localparam int OFF_W  = $clog2(LINE_B);
  localparam int WB_W   = $clog2(WORD_W / 8);
  localparam int WSEL_W = OFF_W - WB_W;
  localparam logic [AW-1:0] BYP_MASK = AW'(1) << BYP_BIT;
  localparam logic [AW-1:0] OFF_MASK = AW'(LINE_B - 1);

  function automatic logic [AW-1:0] line_of(input logic [AW-1:0] a);
    return a & ~OFF_MASK;
  endfunction

  function automatic logic [AW-1:0] next_line(input logic [AW-1:0] a);
    return (line_of(a) + AW'(LINE_B)) & ~BYP_MASK;
  endfunction

  state_e            state_q;
  kind_e             kind_q;
  logic [AW-1:0]     cur_addr_q;
  logic [WORD_W-1:0] cur_wdata_q;
  logic              rsp_valid_q;
  logic [WORD_W-1:0] rsp_data_q;
  logic              pf_pend_q;
  logic [AW-1:0]     pf_line_q;
  logic              last_pf_vld_q;
  logic [AW-1:0]     last_pf_q;

  logic              accept, req_byp, pf_go;
  logic [AW-1:0]     req_canon;
  logic [WORD_W-1:0] rsp_words [LINE_WORDS];

  assign req_ready = (state_q == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign req_byp   = req_nocache || req_addr[BYP_BIT];
  assign req_canon = req_addr & ~BYP_MASK;
  assign pf_go     = (state_q == S_IDLE) && !req_valid && pf_pend_q && pf_enable;
  assign pf_addr   = pf_line_q;

  assign wr_en     = accept && req_write && !req_byp && lk_hit;
  assign fill_en   = (state_q == S_MRSP) && mem_rsp_valid && (kind_q == K_FILL || kind_q == K_PF);
  assign fill_addr = cur_addr_q;

  assign mem_req_valid = (state_q == S_MREQ);
  assign mem_req_write = (kind_q == K_WR);
  assign mem_req_addr  = (kind_q == K_WR) ? cur_addr_q : line_of(cur_addr_q);
  assign mem_req_wdata = cur_wdata_q;

  for (genvar k = 0; k < LINE_WORDS; k++) begin : g_words
    assign rsp_words[k] = mem_rsp_data[k*WORD_W +: WORD_W];
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= S_IDLE;
      kind_q        <= K_FILL;
      rsp_valid_q   <= 1'b0;
      rsp_data_q    <= '0;
      pf_pend_q     <= 1'b0;
      pf_line_q     <= '0;
      last_pf_vld_q <= 1'b0;
      last_pf_q     <= '0;
      cur_addr_q    <= '0;
      cur_wdata_q   <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (accept) begin
            pf_pend_q   <= 1'b0;
            cur_addr_q  <= req_canon;
            cur_wdata_q <= req_wdata;
            if (req_write) begin
              kind_q  <= K_WR;
              state_q <= S_MREQ;
            end else if (!req_byp && lk_hit) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= lk_word;
              if (pf_enable && last_pf_vld_q && line_of(req_canon) == last_pf_q) begin
                pf_pend_q <= 1'b1;
                pf_line_q <= next_line(req_canon);
              end
            end else begin
              kind_q  <= req_byp ? K_BYP : K_FILL;
              state_q <= S_MREQ;
            end
          end else if (pf_go) begin
            pf_pend_q <= 1'b0;
            if (!pf_hit) begin
              kind_q     <= K_PF;
              cur_addr_q <= pf_line_q;
              state_q    <= S_MREQ;
            end
          end
        end
        S_MREQ: begin
          if (mem_req_ready) begin
            if (kind_q == K_WR) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= '0;
              state_q     <= S_IDLE;
            end else begin
              state_q <= S_MRSP;
            end
          end
        end
        S_MRSP: begin
          if (mem_rsp_valid) begin
            state_q <= S_IDLE;
            if (kind_q == K_PF) begin
              last_pf_vld_q <= 1'b1;
              last_pf_q     <= line_of(cur_addr_q);
            end else begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= rsp_words[cur_addr_q[WB_W +: WSEL_W]];
              if (kind_q == K_FILL && pf_enable) begin
                pf_pend_q <= 1'b1;
                pf_line_q <= next_line(cur_addr_q);
              end
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcache_bypass.sv
module dcache_bypass #(
  parameter int AW         = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 8,
  parameter int IDX_W      = 6,
  parameter int BYP_BIT    = 29
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         pf_enable,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic                         req_nocache,
  input  logic [AW-1:0]                req_addr,
  input  logic [WORD_W-1:0]            req_wdata,
  output logic                         rsp_valid,
  output logic [WORD_W-1:0]            rsp_rdata,
  output logic                         mem_req_valid,
  input  logic                         mem_req_ready,
  output logic                         mem_req_write,
  output logic [AW-1:0]                mem_req_addr,
  output logic [WORD_W-1:0]            mem_req_wdata,
  input  logic                         mem_rsp_valid,
  input  logic [LINE_WORDS*WORD_W-1:0] mem_rsp_data,
  input  logic                         snp_valid,
  input  logic [AW-1:0]                snp_addr,
  input  logic [WORD_W-1:0]            snp_data
);
  logic              lk_hit, pf_hit, wr_en, fill_en;
  logic [WORD_W-1:0] lk_word;
  logic [AW-1:0]     pf_addr, fill_addr;

  dcb_ctrl #(
    .AW(AW), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .BYP_BIT(BYP_BIT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .pf_enable(pf_enable),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_nocache(req_nocache), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .lk_hit(lk_hit), .lk_word(lk_word), .pf_addr(pf_addr), .pf_hit(pf_hit),
    .wr_en(wr_en), .fill_en(fill_en), .fill_addr(fill_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  dcb_store #(
    .AW(AW), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .IDX_W(IDX_W), .BYP_BIT(BYP_BIT)
  ) u_store (
    .clk(clk), .rst(rst),
    .lk_addr(req_addr), .lk_hit(lk_hit), .lk_word(lk_word),
    .pf_addr(pf_addr), .pf_hit(pf_hit),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(mem_rsp_data),
    .wr_en(wr_en), .wr_addr(req_addr), .wr_data(req_wdata),
    .snp_en(snp_valid), .snp_addr(snp_addr), .snp_data(snp_data)
  );
endmodule

// File: rtl/dcb_chk.sv
module dcb_chk #(
  parameter int AW      = 32,
  parameter int BYP_BIT = 29
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic          rsp_valid,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [AW-1:0] mem_req_addr
);
  // R4
  alias_clear_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !mem_req_addr[BYP_BIT]);

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

  // R12
  one_read_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_ready && !mem_req_write) |=> !mem_req_valid);

  // R7
  write_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_write) |=> !rsp_valid);

  // R12
  busy_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_write) |=> !req_ready);
endmodule

bind dcache_bypass dcb_chk #(.AW(AW), .BYP_BIT(BYP_BIT)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
  .mem_req_addr(mem_req_addr)
);

// File: tb/sim_dcache_bypass.sv
`timescale 1ns/1ps
module sim_dcache_bypass;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst = 1'b1, pf_enable = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0, req_nocache = 1'b0;
  logic [31:0]  req_addr = '0, req_wdata = '0;
  logic         req_ready, rsp_valid;
  logic [31:0]  rsp_rdata;
  logic         mem_req_valid, mem_req_write;
  logic [31:0]  mem_req_addr, mem_req_wdata;
  logic         mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [255:0] mem_rsp_data = '0;
  logic         snp_valid = 1'b0;
  logic [31:0]  snp_addr = '0, snp_data = '0;

  dcache_bypass u0 (
    .clk(clk), .rst(rst), .pf_enable(pf_enable),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_nocache(req_nocache), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_data(snp_data)
  );

  int total = 0, bad = 0;
  int rd_cnt = 0, wr_cnt = 0, cyc = 0;
  logic [31:0] last_rd = '0;
  bit [31:0] ovr [bit [31:0]];
  logic pend = 1'b0;
  int pcnt = 0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[15:0]};
  endfunction

  function automatic logic [31:0] memrd(input logic [31:0] a);
    if (ovr.exists(a)) return ovr[a];
    return pat(a);
  endfunction

  // memory model: ready stalls one cycle in three, line data two cycles after accept
  always @(posedge clk) begin
    cyc = cyc + 1;
    mem_req_ready <= (cyc % 3) != 1;
    mem_rsp_valid <= 1'b0;
    if (rst) begin
      pend <= 1'b0;
    end else begin
      if (snp_valid) ovr[snp_addr] = snp_data;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          ovr[mem_req_addr] = mem_req_wdata;
          wr_cnt = wr_cnt + 1;
        end else begin
          rd_cnt  = rd_cnt + 1;
          last_rd = mem_req_addr;
          pend <= 1'b1;
          pcnt <= 1;
        end
      end
      if (pend) begin
        if (pcnt == 0) begin
          mem_rsp_valid <= 1'b1;
          for (int k = 0; k < 8; k++) mem_rsp_data[k*32 +: 32] <= memrd(last_rd + 32'(4*k));
          pend <= 1'b0;
        end else begin
          pcnt <= pcnt - 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  // lat = falling edges waited after the one following acceptance
  task automatic access(input logic w, input logic nc, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rdata, output int lat, output logic prev_mrsp,
                        output logic ready_after);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_nocache = nc; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    ready_after = req_ready;
    lat = 0;
    prev_mrsp = 1'b0;
    while (!rsp_valid && lat < 300) begin
      prev_mrsp = mem_rsp_valid;
      lat++;
      @(negedge clk);
    end
    rdata = rsp_rdata;
  endtask

  task automatic snoop(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    snp_valid = 1'b1; snp_addr = a; snp_data = d;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  typedef struct packed {
    logic        w;
    logic        nc;
    logic [31:0] a;
    logic [31:0] d;
    logic        use_pat;
    logic [31:0] e;
    logic [3:0]  nr;
    logic [3:0]  nw;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b0, 32'h0000_1040, 32'h0, 1'b1, 32'h0,         4'd1, 4'd0}, // R2 cold miss
    '{1'b0, 1'b0, 32'h0000_1044, 32'h0, 1'b1, 32'h0,         4'd0, 4'd0}, // R3 hit
    '{1'b0, 1'b0, 32'h2000_1048, 32'h0, 1'b1, 32'h0,         4'd1, 4'd0}, // R4 alias goes to memory
    '{1'b0, 1'b0, 32'h0000_1048, 32'h0, 1'b1, 32'h0,         4'd0, 4'd0}, // R4 cached twin still hits
    '{1'b0, 1'b1, 32'h0000_2000, 32'h0, 1'b1, 32'h0,         4'd1, 4'd0}, // R5 flag bypass
    '{1'b0, 1'b0, 32'h0000_2000, 32'h0, 1'b1, 32'h0,         4'd1, 4'd0}, // R6 not allocated
    '{1'b0, 1'b0, 32'h0000_2004, 32'h0, 1'b1, 32'h0,         4'd0, 4'd0}, // R6 now cached
    '{1'b1, 1'b0, 32'h0000_1044, 32'h1234_5678, 1'b0, 32'h0, 4'd0, 4'd1}, // R7 write hit
    '{1'b0, 1'b0, 32'h0000_1044, 32'h0, 1'b0, 32'h1234_5678, 4'd0, 4'd0}, // R7 updated line
    '{1'b1, 1'b0, 32'h0000_3000, 32'hCAFE_0001, 1'b0, 32'h0, 4'd0, 4'd1}, // R7 write miss
    '{1'b0, 1'b0, 32'h0000_3000, 32'h0, 1'b0, 32'hCAFE_0001, 4'd1, 4'd0}  // R7 no allocation
  };

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL R12 watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int lat, r0, w0;
    logic pm, ra;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 req_ready", {31'b0, req_ready}, 32'd1);
    chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R1 mem_req_valid", {31'b0, mem_req_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      r0 = rd_cnt; w0 = wr_cnt;
      access(TBL[i].w, TBL[i].nc, TBL[i].a, TBL[i].d, rd, lat, pm, ra);
      if (!TBL[i].w)
        chk($sformatf("table[%0d] R2/R3 rdata", i), rd,
            TBL[i].use_pat ? pat(TBL[i].a & 32'hDFFF_FFFF) : TBL[i].e);
      chk($sformatf("table[%0d] mem reads", i), 32'(rd_cnt - r0), 32'(TBL[i].nr));
      chk($sformatf("table[%0d] R7 mem writes", i), 32'(wr_cnt - w0), 32'(TBL[i].nw));
      if (!TBL[i].w && TBL[i].nr == 0) chk($sformatf("table[%0d] R3 latency", i), 32'(lat), 32'd0);
    end

    // R4 alias reaches memory with bit 29 cleared, line aligned
    access(1'b0, 1'b0, 32'h2000_1064, 32'h0, rd, lat, pm, ra);
    chk("R4 mem addr", last_rd, 32'h0000_1060);
    chk("R4 rdata", rd, pat(32'h0000_1064));

    // R2 miss timing, alignment, word select; R12 busy while outstanding
    access(1'b0, 1'b0, 32'h0000_4014, 32'h0, rd, lat, pm, ra);
    chk("R2 line address", last_rd, 32'h0000_4000);
    chk("R2 word select", rd, pat(32'h0000_4014));
    chk("R2 response one cycle after memory", {31'b0, pm}, 32'd1);
    chk("R12 not ready during miss", {31'b0, ra}, 32'd0);

    // R6 uncached read at the same index does not evict
    r0 = rd_cnt;
    access(1'b0, 1'b1, 32'h0000_1840, 32'h0, rd, lat, pm, ra);
    access(1'b0, 1'b0, 32'h0000_1040, 32'h0, rd, lat, pm, ra);
    chk("R6 line kept reads", 32'(rd_cnt - r0), 32'd1);
    chk("R6 line kept data", rd, pat(32'h0000_1040));

    // R6 uncached write leaves cached copy untouched
    access(1'b1, 1'b1, 32'h0000_104C, 32'hDEAD_0000, rd, lat, pm, ra);
    r0 = rd_cnt;
    access(1'b0, 1'b0, 32'h0000_104C, 32'h0, rd, lat, pm, ra);
    chk("R6 bypass write no tag match", rd, pat(32'h0000_104C));
    chk("R6 bypass write reads", 32'(rd_cnt - r0), 32'd0);

    // R8 snoop updates a present line, allocates nothing otherwise
    snoop(32'h0000_1050, 32'h55AA_0001);
    r0 = rd_cnt;
    access(1'b0, 1'b0, 32'h0000_1050, 32'h0, rd, lat, pm, ra);
    chk("R8 snoop hit data", rd, 32'h55AA_0001);
    chk("R8 snoop hit reads", 32'(rd_cnt - r0), 32'd0);
    snoop(32'h0000_5000, 32'h7777_0002);
    r0 = rd_cnt;
    access(1'b0, 1'b0, 32'h0000_5000, 32'h0, rd, lat, pm, ra);
    chk("R8 snoop miss no allocate", 32'(rd_cnt - r0), 32'd1);
    chk("R8 snoop miss data", rd, 32'h7777_0002);

    // R11 prefetch to an already valid line is dropped
    access(1'b0, 1'b0, 32'h0000_7020, 32'h0, rd, lat, pm, ra);
    pf_enable = 1'b1;
    r0 = rd_cnt;
    access(1'b0, 1'b0, 32'h0000_7000, 32'h0, rd, lat, pm, ra);
    repeat (12) @(negedge clk);
    chk("R11 drop valid target", 32'(rd_cnt - r0), 32'd1);

    // R9 next-line prefetch after a demand miss
    r0 = rd_cnt;
    access(1'b0, 1'b0, 32'h0000_6004, 32'h0, rd, lat, pm, ra);
    repeat (12) @(negedge clk);
    chk("R9 prefetch issued", 32'(rd_cnt - r0), 32'd2);
    chk("R9 prefetch address", last_rd, 32'h0000_6020);
    r0 = rd_cnt;
    access(1'b0, 1'b0, 32'h0000_6024, 32'h0, rd, lat, pm, ra);
    chk("R9 prefetched line hits", {rd_cnt - r0 == 0 ? 32'd0 : 32'd1}, 32'd0);
    chk("R9 prefetched data", rd, pat(32'h0000_6024));

    // R10 hit on prefetched line chains the next prefetch
    repeat (12) @(negedge clk);
    chk("R10 chained prefetch", 32'(rd_cnt - r0), 32'd1);
    chk("R10 chained address", last_rd, 32'h0000_6040);
    r0 = rd_cnt;
    access(1'b0, 1'b0, 32'h0000_6040, 32'h0, rd, lat, pm, ra);
    chk("R10 chained line hits", 32'(rd_cnt - r0), 32'd0);
    repeat (12) @(negedge clk);

    // R1 reset clears valid bits; R11 no prefetch before first miss
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    r0 = rd_cnt;
    repeat (12) @(negedge clk);
    chk("R11 no prefetch after reset", 32'(rd_cnt - r0), 32'd0);
    access(1'b0, 1'b0, 32'h0000_6040, 32'h0, rd, lat, pm, ra);
    chk("R1 first read misses", 32'(rd_cnt - r0), 32'd1);

    summary();
    $finish;
  end
endmodule